// File: doc/BRIEF.md
# LIN Bus Remote Wake Detector

This block watches a LIN bus while the transceiver sits in one of its two low-power modes and decides when a remote node has asked it to wake. It does not see analog levels. Three comparator flags describe the bus: below the pre-wake low level, dominant, and above the pre-wake high level. A two-bit mode code from the on-chip mode controller and the level of the transmit data pin complete its inputs. All inputs are synchronised before use.

A bus level below the pre-wake low level switches the wake receiver on and starts a monitor window. A recessive-to-dominant transition, then a dominant level held longer than a programmable filter time, then a release, gives a one-cycle wake pulse. The wake pulse also raises the termination request. If the monitor window runs out first, the receiver is switched off again to save current. What happens next depends on the bus level at that moment. A bus that is still dominant counts as shorted to ground, and its next release wakes the node directly. A bus that floats between the pre-wake low level and the dominant level stays ignored until it has risen above the pre-wake high level for a programmed time. A bus that has already gone back above the pre-wake low level simply re-arms the detector.

All timing is given in clock cycles through parameters, so one detector serves any clock rate.

Top module: `lin_wake_det`

## Requirements
- R1: While the mode code is 00 (no low-power mode), and after reset, wake_o is 0, rx_en_o is 0 and term_en_o is 1. All three reach these values one clock edge after the code becomes 00.
- R2: After entering a low-power mode, term_en_o and rx_en_o are 0 until the below-low flag is seen. rx_en_o then rises SYNC_STAGES+1 clock edges after that flag is applied.
- R3: The dominant flag must rise and then stay high for more than TBUS_CYC cycles before it falls. When it falls, wake_o pulses SYNC_STAGES+1 edges after the fall. A dominant level held for exactly TBUS_CYC cycles gives no wake.
- R4: Mode code 01 (silent) accepts a wake only while txd_i is 1 at the release. Codes 10 and 11 (sleep) accept it whatever the level of txd_i.
- R5: wake_o is high for exactly one cycle. After a wake, term_en_o is 1 and rx_en_o is 0, and no further wake is issued until the low-power mode is left.
- R6: When no wake happens, rx_en_o stays high for exactly TMON_CYC cycles. If the bus is floating when the window ends (below-low set, dominant clear), rx_en_o falls and no wake is issued.
- R7: After a floating-bus timeout, dominant pulses of any length are ignored and rx_en_o stays 0. This lasts until the above-high flag has been high for REARM_CYC consecutive cycles.
- R8: If the bus is dominant when the window ends, rx_en_o falls. The next release of the dominant level then issues a wake whatever the pulse length, subject to R4, with the latency of R3.
- R9: If the bus is neither below the low level nor dominant when the window ends, the detector is armed again at once, with no need for the above-high flag.
- R10: Leaving the low-power modes clears all timers and state. On re-entry, detection starts afresh, including after an earlier wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_mode_i | input | 2 | Mode code: 00 none, 01 silent, 10 or 11 sleep |
| bus_below_lo_i | input | 1 | Bus below the pre-wake low level |
| bus_dom_i | input | 1 | Bus at dominant level |
| bus_above_hi_i | input | 1 | Bus above the pre-wake high level |
| txd_i | input | 1 | Level of the transmit data pin |
| wake_o | output | 1 | One-cycle remote wake pulse |
| rx_en_o | output | 1 | Wake receiver enable (current saving) |
| term_en_o | output | 1 | Bus termination enable request |

## Verification
Every bus input passes through SYNC_STAGES flops. The dominant flag then goes through one edge register, and the controller reacts on the next edge. So wake_o appears SYNC_STAGES+1 edges after the release is driven, and rx_en_o rises SYNC_STAGES+1 edges after the below-low flag is driven. The bench drives inputs two nanoseconds after a rising edge and stamps each release with the current cycle number. A monitor on the falling edge stamps every wake pulse, so latency is checked by subtracting the two stamps. The same monitor measures how long rx_en_o stays high, which gives the window length of exactly TMON_CYC cycles. Results that are absent, such as no wake or a receiver that stays off, are checked only after the full SYNC_STAGES+4 cycle settling time has passed.

// File: rtl/lwk_pkg.sv
package lwk_pkg;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_IDLE  = 3'd1,
      ST_MON   = 3'd2,
      ST_FLOAT = 3'd3,
      ST_SHORT = 3'd4,
      ST_DONE  = 3'd5
   } lwk_state_e;

   localparam logic [1:0] LP_NONE   = 2'd0;
   localparam logic [1:0] LP_SILENT = 2'd1;

   typedef struct packed {
      logic txd;
      logic above_hi;
      logic dom;
      logic below_lo;
   } lwk_bus_t;

   function automatic logic wake_allowed(input logic [1:0] mode, input logic txd);
      return (mode == LP_SILENT) ? txd : 1'b1;
   endfunction

endpackage

// File: rtl/lwk_sync.sv
module lwk_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("lwk_sync: STAGES must lie in 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stg_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
         end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         end
      end
      assign q_o = stg_q[STAGES-1];
   end

endmodule

// File: rtl/lwk_edge.sv
module lwk_edge #(
   parameter int WIDTH = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);

   logic [WIDTH-1:0] d_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) d_q <= '0;
      else         d_q <= d_i;
   end

   assign rise_o = d_i & ~d_q;
   assign fall_o = ~d_i & d_q;

endmodule

// File: rtl/lwk_timer.sv
module lwk_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic en_i,
   output logic hit_o
);

   localparam int            CW  = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);
   localparam logic [CW-1:0] ONE = CW'(1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("lwk_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   assign hit_o = en_i && (cnt_q == TOP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (clr_i)             cnt_q <= '0;
      else if (en_i && !hit_o)    cnt_q <= cnt_q + ONE;
   end

endmodule

// File: rtl/lwk_dom_filter.sv
module lwk_dom_filter #(
   parameter int TBUS_CYC = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic track_i,
   input  logic dom_i,
   input  logic rise_i,
   input  logic fall_i,
   output logic long_o
);

   localparam int            CNT_MAX = TBUS_CYC + 1;
   localparam int            CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] SAT     = CW'(CNT_MAX);
   localparam logic [CW-1:0] THR     = CW'(TBUS_CYC);
   localparam logic [CW-1:0] ONE     = CW'(1);

   logic          seen_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!track_i || fall_i) begin
         seen_q <= 1'b0;
         cnt_q  <= '0;
      end else if (rise_i) begin
         seen_q <= 1'b1;
         cnt_q  <= ONE;
      end else if (seen_q && dom_i && cnt_q < SAT) begin
         cnt_q  <= cnt_q + ONE;
      end
   end

   assign long_o = seen_q && (cnt_q > THR);

endmodule

// File: rtl/lwk_fsm.sv
module lwk_fsm
   import lwk_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] lp_mode_i,
   input  logic       below_lo_i,
   input  logic       dom_i,
   input  logic       txd_i,
   input  logic       dom_fall_i,
   input  logic       dom_long_i,
   input  logic       mon_hit_i,
   input  logic       rearm_hit_i,
   output lwk_state_e state_o,
   output logic       wake_o,
   output logic       rx_en_o,
   output logic       term_en_o
);

   lwk_state_e st_q, st_n;
   logic       wake_q, wake_n;
   logic       lp_on, ok;

   assign lp_on = (lp_mode_i != LP_NONE);
   assign ok    = wake_allowed(lp_mode_i, txd_i);

   always_comb begin
      st_n   = st_q;
      wake_n = 1'b0;
      if (!lp_on) begin
         st_n = ST_OFF;
      end else begin
         case (st_q)
            ST_OFF:   st_n = ST_IDLE;
            ST_IDLE:  if (below_lo_i) st_n = ST_MON;
            ST_MON: begin
               if (dom_fall_i && dom_long_i && ok) begin
                  wake_n = 1'b1;
                  st_n   = ST_DONE;
               end else if (mon_hit_i) begin
                  if (dom_i)           st_n = ST_SHORT;
                  else if (below_lo_i) st_n = ST_FLOAT;
                  else                 st_n = ST_IDLE;
               end
            end
            ST_FLOAT: if (rearm_hit_i) st_n = ST_IDLE;
            ST_SHORT: begin
               if (dom_fall_i) begin
                  if (ok) begin
                     wake_n = 1'b1;
                     st_n   = ST_DONE;
                  end else begin
                     st_n   = ST_IDLE;
                  end
               end
            end
            ST_DONE:  st_n = ST_DONE;
            default:  st_n = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_OFF;
         wake_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         wake_q <= wake_n;
      end
   end

   assign state_o   = st_q;
   assign wake_o    = wake_q;
   assign rx_en_o   = (st_q == ST_MON);
   assign term_en_o = (st_q == ST_OFF) || (st_q == ST_DONE);

endmodule

// File: rtl/lin_wake_det.sv
module lin_wake_det
   import lwk_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TBUS_CYC    = 11250,
   parameter int TMON_CYC    = 1250000,
   parameter int REARM_CYC   = 500
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] lp_mode_i,
   input  logic       bus_below_lo_i,
   input  logic       bus_dom_i,
   input  logic       bus_above_hi_i,
   input  logic       txd_i,
   output logic       wake_o,
   output logic       rx_en_o,
   output logic       term_en_o
);

   localparam int BUS_W = $bits(lwk_bus_t);

   if (TBUS_CYC < 1) begin : g_bad_tbus
      $error("lin_wake_det: TBUS_CYC must be at least 1");
   end
   if (TMON_CYC <= TBUS_CYC) begin : g_bad_tmon
      $error("lin_wake_det: TMON_CYC must exceed TBUS_CYC");
   end
   if (REARM_CYC < 1) begin : g_bad_rearm
      $error("lin_wake_det: REARM_CYC must be at least 1");
   end

   lwk_bus_t   bus_raw, bus_s;
   logic       txd_s;
   logic       dom_rise_w, dom_fall_w, dom_long_w;
   logic       mon_hit_w, rearm_hit_w;
   logic       lp_on, track_w, float_hi_w;
   lwk_state_e st_w;

   assign bus_raw = '{txd: txd_i, above_hi: bus_above_hi_i,
                      dom: bus_dom_i, below_lo: bus_below_lo_i};

   lwk_sync #(
      .WIDTH   (BUS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (BUS_W'(4'b1100))
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (bus_raw),
      .q_o    (bus_s)
   );

   assign txd_s = bus_s.txd;

   lwk_edge #(.WIDTH(1)) edge_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (bus_s.dom),
      .rise_o (dom_rise_w),
      .fall_o (dom_fall_w)
   );

   assign lp_on   = (lp_mode_i != LP_NONE);
   assign track_w = lp_on && ((st_w == ST_IDLE) || (st_w == ST_MON));

   lwk_dom_filter #(.TBUS_CYC(TBUS_CYC)) filt_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .track_i (track_w),
      .dom_i   (bus_s.dom),
      .rise_i  (dom_rise_w),
      .fall_i  (dom_fall_w),
      .long_o  (dom_long_w)
   );

   lwk_timer #(.LIMIT(TMON_CYC)) mon_tmr_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (st_w != ST_MON),
      .en_i   (st_w == ST_MON),
      .hit_o  (mon_hit_w)
   );

   assign float_hi_w = (st_w == ST_FLOAT) && bus_s.above_hi;

   lwk_timer #(.LIMIT(REARM_CYC)) rearm_tmr_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!float_hi_w),
      .en_i   (float_hi_w),
      .hit_o  (rearm_hit_w)
   );

   lwk_fsm fsm_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lp_mode_i   (lp_mode_i),
      .below_lo_i  (bus_s.below_lo),
      .dom_i       (bus_s.dom),
      .txd_i       (txd_s),
      .dom_fall_i  (dom_fall_w),
      .dom_long_i  (dom_long_w),
      .mon_hit_i   (mon_hit_w),
      .rearm_hit_i (rearm_hit_w),
      .state_o     (st_w),
      .wake_o      (wake_o),
      .rx_en_o     (rx_en_o),
      .term_en_o   (term_en_o)
   );

endmodule

// File: rtl/lin_wake_det_chk.sv
module lin_wake_det_chk #(
   parameter int TMON_CYC = 16
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] lp_mode_i,
   input logic       wake_o,
   input logic       rx_en_o,
   input logic       term_en_o,
   input logic       dom_fall,
   input logic       txd_sync
);

   localparam int           RW  = $clog2(TMON_CYC + 2);
   localparam logic [RW-1:0] LIM = RW'(TMON_CYC);
   localparam logic [RW-1:0] ONE = RW'(1);

   logic [RW-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    run_q <= '0;
      else if (!rx_en_o)              run_q <= '0;
      else if (run_q <= LIM)          run_q <= run_q + ONE;
   end

   p_idle_outputs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lp_mode_i == 2'd0) |=> (!rx_en_o && term_en_o && !wake_o));

   p_wake_in_lp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> ($past(lp_mode_i) != 2'd0));

   p_wake_on_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> $past(dom_fall));

   p_silent_txd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> (($past(lp_mode_i) != 2'd1) || $past(txd_sync)));

   p_wake_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |=> !wake_o);

   p_after_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> (term_en_o && !rx_en_o));

   p_rx_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= LIM);

endmodule

bind lin_wake_det lin_wake_det_chk #(.TMON_CYC(TMON_CYC)) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .lp_mode_i (lp_mode_i),
   .wake_o    (wake_o),
   .rx_en_o   (rx_en_o),
   .term_en_o (term_en_o),
   .dom_fall  (dom_fall_w),
   .txd_sync  (txd_s)
);

// File: tb/lin_wake_det_tb_top.sv
module lin_wake_det_tb_top;

   localparam int TB_SYNC  = 2;
   localparam int TB_TBUS  = 16;
   localparam int TB_TMON  = 300;
   localparam int TB_REARM = 6;
   localparam int LAT      = TB_SYNC + 1;

   localparam int B_HIGH  = 0;
   localparam int B_MID   = 1;
   localparam int B_FLOAT = 2;
   localparam int B_DOM   = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] lp_mode = 2'd0;
   logic       lo = 1'b0, dom = 1'b0, hi = 1'b1, txd = 1'b1;
   logic       wake, rx_en, term_en;

   int checks = 0, failures = 0;
   int cyc = 0;
   int wake_cnt = 0, wake_cyc = 0, wake_run = 0, wake_max = 0;
   int rx_len = 0, last_rx_len = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   lin_wake_det #(
      .SYNC_STAGES (TB_SYNC),
      .TBUS_CYC    (TB_TBUS),
      .TMON_CYC    (TB_TMON),
      .REARM_CYC   (TB_REARM)
   ) dut_i (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .lp_mode_i      (lp_mode),
      .bus_below_lo_i (lo),
      .bus_dom_i      (dom),
      .bus_above_hi_i (hi),
      .txd_i          (txd),
      .wake_o         (wake),
      .rx_en_o        (rx_en),
      .term_en_o      (term_en)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (wake) begin
            wake_cnt++;
            wake_cyc = cyc;
            wake_run++;
            if (wake_run > wake_max) wake_max = wake_run;
         end else begin
            wake_run = 0;
         end
         if (rx_en) rx_len++;
         else if (rx_len != 0) begin
            last_rx_len = rx_len;
            rx_len = 0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic set_bus(input int lvl);
      case (lvl)
         B_HIGH:  begin hi = 1'b1; lo = 1'b0; dom = 1'b0; end
         B_MID:   begin hi = 1'b0; lo = 1'b0; dom = 1'b0; end
         B_FLOAT: begin hi = 1'b0; lo = 1'b1; dom = 1'b0; end
         default: begin hi = 1'b0; lo = 1'b1; dom = 1'b1; end
      endcase
   endtask

   task automatic restart(input logic [1:0] mode, input logic t);
      lp_mode = 2'd0;
      txd = t;
      set_bus(B_HIGH);
      tick(6);
      lp_mode = mode;
      tick(3);
   endtask

   // dominant pulse of w cycles, release to level rel; returns wakes seen and latency
   task automatic dom_trial(input int w, input int rel, output int n, output int lat);
      int base, rel_cyc;
      base = wake_cnt;
      set_bus(B_DOM);
      tick(w);
      set_bus(rel);
      rel_cyc = cyc;
      tick(TB_SYNC + 4);
      n = wake_cnt - base;
      lat = wake_cyc - rel_cyc;
   endtask

   function automatic int exp_wakes(input int w, input logic [1:0] mode, input logic t);
      return (w > TB_TBUS && (mode != 2'd1 || t)) ? 1 : 0;
   endfunction

   initial begin
      int n, lat;
      void'($urandom(32'd7331));
      tick(5);
      // R1: reset state
      check(wake == 1'b0 && rx_en == 1'b0 && term_en == 1'b1, "R1 reset outputs",
            {wake, rx_en, term_en}, 3'b001);
      rst_n = 1'b1;
      tick(3);
      check(rx_en == 1'b0 && term_en == 1'b1, "R1 mode 00 outputs", {rx_en, term_en}, 2'b01);

      // R2: enter sleep, receiver off until below-low
      lp_mode = 2'd2;
      tick(3);
      check(term_en == 1'b0 && rx_en == 1'b0, "R2 low-power idle", {rx_en, term_en}, 2'b00);
      set_bus(B_FLOAT);
      tick(LAT - 1);
      check(rx_en == 1'b0, "R2 rx_en not before latency", rx_en, 0);
      tick(1);
      check(rx_en == 1'b1, "R2 rx_en at latency", rx_en, 1);
      // R1: leaving low power mid-window
      lp_mode = 2'd0;
      tick(1);
      check(rx_en == 1'b0 && term_en == 1'b1, "R1 exit one edge", {rx_en, term_en}, 2'b01);

      // R3: filter boundary
      restart(2'd2, 1'b1);
      dom_trial(TB_TBUS, B_HIGH, n, lat);
      check(n == 0, "R3 exactly TBUS no wake", n, 0);
      restart(2'd2, 1'b1);
      dom_trial(TB_TBUS + 1, B_HIGH, n, lat);
      check(n == 1, "R3 TBUS+1 wakes", n, 1);
      check(lat == LAT, "R3 wake latency", lat, LAT);
      // R5: after wake
      check(term_en == 1'b1 && rx_en == 1'b0, "R5 after wake outputs", {rx_en, term_en}, 2'b01);
      dom_trial(TB_TBUS + 5, B_HIGH, n, lat);
      check(n == 0, "R5 no second wake", n, 0);

      // R4: mode and txd
      restart(2'd1, 1'b0);
      dom_trial(TB_TBUS + 5, B_HIGH, n, lat);
      check(n == 0, "R4 silent txd low", n, 0);
      restart(2'd1, 1'b1);
      dom_trial(TB_TBUS + 5, B_HIGH, n, lat);
      check(n == 1, "R4 silent txd high", n, 1);
      restart(2'd2, 1'b0);
      dom_trial(TB_TBUS + 5, B_HIGH, n, lat);
      check(n == 1, "R4 sleep txd low", n, 1);
      restart(2'd3, 1'b0);
      dom_trial(TB_TBUS + 5, B_HIGH, n, lat);
      check(n == 1, "R4 code 11 txd low", n, 1);

      // R6/R7: floating bus
      restart(2'd2, 1'b1);
      n = wake_cnt;
      set_bus(B_FLOAT);
      tick(TB_TMON + 8);
      check(rx_en == 1'b0, "R6 rx off after float timeout", rx_en, 0);
      check(last_rx_len == TB_TMON, "R6 window length", last_rx_len, TB_TMON);
      check(wake_cnt == n, "R6 no wake on float", wake_cnt - n, 0);
      dom_trial(TB_TBUS + 5, B_MID, n, lat);
      check(n == 0 && rx_en == 1'b0, "R7 dominant ignored after float", n, 0);
      set_bus(B_HIGH);
      tick(TB_REARM - 1);
      dom_trial(TB_TBUS + 5, B_MID, n, lat);
      check(n == 0 && rx_en == 1'b0, "R7 short high not enough", n, 0);
      set_bus(B_HIGH);
      tick(TB_REARM + 4);
      dom_trial(TB_TBUS + 5, B_HIGH, n, lat);
      check(n == 1, "R7 re-armed after high", n, 1);

      // R8: shorted bus
      restart(2'd2, 1'b0);
      n = wake_cnt;
      set_bus(B_DOM);
      tick(TB_TMON + 20);
      check(rx_en == 1'b0 && wake_cnt == n, "R8 rx off on short", rx_en, 0);
      check(last_rx_len == TB_TMON, "R8 window length", last_rx_len, TB_TMON);
      dom_trial(0, B_HIGH, n, lat);
      check(n == 1, "R8 release wakes", n, 1);
      check(lat == LAT, "R8 release latency", lat, LAT);
      restart(2'd1, 1'b0);
      set_bus(B_DOM);
      tick(TB_TMON + 20);
      dom_trial(0, B_HIGH, n, lat);
      check(n == 0, "R8 silent txd low blocks", n, 0);

      // R9: bus between thresholds at timeout
      restart(2'd2, 1'b1);
      set_bus(B_FLOAT);
      tick(5);
      set_bus(B_MID);
      tick(TB_TMON + 5);
      check(rx_en == 1'b0, "R9 rx off", rx_en, 0);
      dom_trial(TB_TBUS + 3, B_MID, n, lat);
      check(n == 1, "R9 armed without high", n, 1);

      // R10: re-entry after wake
      restart(2'd2, 1'b1);
      dom_trial(TB_TBUS + 2, B_HIGH, n, lat);
      check(n == 1, "R10 fresh wake after re-entry", n, 1);

      // random trials
      for (int k = 0; k < 40; k++) begin
         logic [1:0] m;
         logic       t;
         int         w;
         m = 2'd1 + 2'($urandom % 3);
         t = 1'($urandom % 2);
         w = 1 + int'($urandom % (2 * TB_TBUS + 4));
         restart(m, t);
         dom_trial(w, B_HIGH, n, lat);
         check(n == exp_wakes(w, m, t), "R3 R4 random trial", n, exp_wakes(w, m, t));
      end

      check(wake_max == 1, "R5 pulse width", wake_max, 1);

      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule